// File: doc/BRIEF.md
# Single-Channel Word DMA with Sticky Error Freeze

This block is one DMA channel. A pulse on `start` loads a descriptor from the input pins: a source address, a destination address, a byte count, and a hold-address flag for each side. The channel then moves the data one 32-bit word at a time. For each word it reads from the source over a simple request/acknowledge memory port and then writes that word to the destination. A side whose hold flag is set uses the same address for every access. With the source held and the destination advancing, the channel fills a region with copies of one word.

Two kinds of failure leave the channel active instead of letting it finish. A descriptor whose byte count is zero, or is not a whole number of words, sets a shared size-error flag. That flag does not say which channel caused it, and the channel stays busy and issues no access. An error response on the memory port freezes the channel. Clearing the status bits does not release a frozen channel. Only a one-cycle reinitialization pulse returns it to idle.

Top module: `dma_freeze_chan`

## Requirements
- R1: After reset, `active`, `frozen`, `port_err`, `size_err` and `mem_req` are all low.
- R2: A start with a valid descriptor runs count/4 read-then-write word pairs. Each request keeps `mem_req`, `mem_we` and `mem_addr` steady until `mem_ack` or `mem_err`. Each write carries the data returned by the read just before it.
- R3: When a side's hold flag is clear, its address starts at the value loaded at start and grows by 4 after each completed word write.
- R4: When a side's hold flag is set, every access on that side uses the loaded address. Source held with destination advancing fills the destination with one word. Destination held leaves the last word copied at that address.
- R5: `active` rises in the cycle after an accepted start and falls in the cycle after the acknowledge of the last write. A start that arrives while `active` is high is ignored.
- R6: A start whose byte count is zero or has a nonzero value in bits [1:0] sets `size_err` in the next cycle. `active` then stays high and no memory request is made until reinitialization.
- R7: `mem_err` during any request sets `port_err` and `frozen` in the next cycle. From then on there are no requests and `active` stays high.
- R8: `err_clr` clears `port_err` and `size_err` (a new error in the same cycle wins). It does not release a frozen or stuck channel, and a start in that state is ignored.
- R9: A `reinit` pulse leaves `active`, `frozen`, `port_err`, `size_err` and `mem_req` low in the next cycle, and it overrides a start given in the same cycle. After it, a new descriptor runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load descriptor and begin (one-cycle pulse) |
| src_addr | input | AW | Source byte address, word aligned |
| dst_addr | input | AW | Destination byte address, word aligned |
| byte_cnt | input | SW | Transfer length in bytes |
| src_hold | input | 1 | Keep source address fixed |
| dst_hold | input | 1 | Keep destination address fixed |
| reinit | input | 1 | Return channel to idle, clearing all state |
| err_clr | input | 1 | Clear the error status bits |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Access byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed |
| active | output | 1 | Channel busy or stuck |
| frozen | output | 1 | Channel frozen by a port error |
| port_err | output | 1 | Port error status bit |
| size_err | output | 1 | Shared bad-size error flag |

## Verification
A wrong control state appears on the port one clock edge after the event that caused it. A missed freeze shows as `mem_req` still high. A wrongly released channel shows as `active` falling. A skipped or repeated word shows as a step in `mem_addr` other than 4 on the next request of that side. A wrong word count shows as one read too many or too few before `active` falls. The bench runs a behavioural model next to the design and compares the status bits and the memory request fields at every clock. Any deviation is therefore reported in the cycle it first appears, and the final memory contents are checked as well.

// File: rtl/dma_fz_pkg.sv
// Shared types for the freezing DMA channel.
// Assumes: one channel, one outstanding access at a time.
package dma_fz_pkg;
    typedef enum logic [2:0] {
        CH_IDLE   = 3'd0,
        CH_READ   = 3'd1,
        CH_WRITE  = 3'd2,
        CH_STUCK  = 3'd3,
        CH_FROZEN = 3'd4
    } chan_st_t;
endpackage

// File: rtl/dma_fz_addr.sv
// One side's address generator. It loads a start address and a hold flag.
// While the flag is clear it steps by STEP bytes on each completed word.
// Assumes: load and step are never high in the same cycle.
module dma_fz_addr #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          load_hold,
    input  logic          step,
    output logic [AW-1:0] addr
);
    logic hold_q;

    // Address register: load on start, advance when not held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            hold_q <= 1'b0;
        end else if (load) begin
            addr   <= load_addr;
            hold_q <= load_hold;
        end else if (step && !hold_q) begin
            addr   <= addr + AW'(STEP);
        end
    end
endmodule

// File: rtl/dma_fz_ctrl.sv
// Channel sequencer: state machine, word counter and the two error bits.
// A bad size parks the channel in STUCK. A port error parks it in FROZEN.
// Only reinit leaves either state. Assumes the size is in bytes and that
// an error response takes priority over an acknowledge in the same cycle.
module dma_fz_ctrl
    import dma_fz_pkg::*;
#(
    parameter int SW = 16,
    parameter int LG = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [SW-1:0] byte_cnt,
    input  logic          reinit,
    input  logic          err_clr,
    input  logic          mem_ack,
    input  logic          mem_err,
    output chan_st_t      state,
    output logic          load,
    output logic          step,
    output logic          capture,
    output logic          port_err,
    output logic          size_err
);
    localparam int CW = SW - LG;

    chan_st_t      nxt;
    logic [CW-1:0] words_left;
    logic          size_bad;
    logic          accept;
    logic          busy;
    logic          set_perr;

    // Decode the descriptor and the one-cycle events.
    always_comb begin
        size_bad = (byte_cnt == '0) || (byte_cnt[LG-1:0] != '0);
        accept   = (state == CH_IDLE) && start && !reinit;
        load     = accept && !size_bad;
        busy     = (state == CH_READ) || (state == CH_WRITE);
        set_perr = busy && mem_err && !reinit;
        capture  = (state == CH_READ) && mem_ack && !mem_err;
        step     = (state == CH_WRITE) && mem_ack && !mem_err && !reinit;
    end

    // Next-state selection; reinit overrides every other event.
    always_comb begin
        nxt = state;
        unique case (state)
            CH_IDLE:   if (accept) nxt = size_bad ? CH_STUCK : CH_READ;
            CH_READ:   if (mem_err) nxt = CH_FROZEN;
                       else if (mem_ack) nxt = CH_WRITE;
            CH_WRITE:  if (mem_err) nxt = CH_FROZEN;
                       else if (mem_ack) nxt = (words_left == CW'(1)) ? CH_IDLE : CH_READ;
            CH_STUCK:  nxt = CH_STUCK;
            CH_FROZEN: nxt = CH_FROZEN;
            default:   nxt = CH_IDLE;
        endcase
        if (reinit) nxt = CH_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= nxt;
    end

    // Remaining word count: load from the byte count, drop on each word.
    always_ff @(posedge clk) begin
        if (!rst_n)    words_left <= '0;
        else if (load) words_left <= byte_cnt[SW-1:LG];
        else if (step) words_left <= words_left - CW'(1);
    end

    // Error status bits: reinit clears, a new error beats err_clr.
    always_ff @(posedge clk) begin
        if (!rst_n || reinit) begin
            port_err <= 1'b0;
            size_err <= 1'b0;
        end else begin
            if (set_perr)     port_err <= 1'b1;
            else if (err_clr) port_err <= 1'b0;
            if (accept && size_bad) size_err <= 1'b1;
            else if (err_clr)       size_err <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_freeze_chan.sv
// Top of the single DMA channel. It wires the sequencer, two address
// generators (source, destination) and the word holding register to the
// memory port. Assumes the memory keeps mem_rdata valid while mem_ack is high.
module dma_freeze_chan
    import dma_fz_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [SW-1:0] byte_cnt,
    input  logic          src_hold,
    input  logic          dst_hold,
    input  logic          reinit,
    input  logic          err_clr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          active,
    output logic          frozen,
    output logic          port_err,
    output logic          size_err
);
    localparam int STEP  = DW / 8;
    localparam int LG    = $clog2(STEP);
    localparam int SIDES = 2;

    chan_st_t                 state;
    logic                     load, step, capture;
    logic [SIDES-1:0][AW-1:0] side_init;
    logic [SIDES-1:0]         side_hold;
    logic [SIDES-1:0][AW-1:0] side_addr;
    logic [DW-1:0]            word_q;

    dma_fz_ctrl #(.SW(SW), .LG(LG)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .byte_cnt (byte_cnt),
        .reinit   (reinit),
        .err_clr  (err_clr),
        .mem_ack  (mem_ack),
        .mem_err  (mem_err),
        .state    (state),
        .load     (load),
        .step     (step),
        .capture  (capture),
        .port_err (port_err),
        .size_err (size_err)
    );

    // Side 0 is the source, side 1 the destination.
    assign side_init = {dst_addr, src_addr};
    assign side_hold = {dst_hold, src_hold};

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        dma_fz_addr #(.AW(AW), .STEP(STEP)) u_addr (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load),
            .load_addr (side_init[g]),
            .load_hold (side_hold[g]),
            .step      (step),
            .addr      (side_addr[g])
        );
    end

    // Holding register: keep the word read until it is written.
    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (capture) word_q <= mem_rdata;
    end

    // Port and status outputs decoded from the state.
    always_comb begin
        mem_req   = (state == CH_READ) || (state == CH_WRITE);
        mem_we    = (state == CH_WRITE);
        mem_addr  = mem_we ? side_addr[1] : side_addr[0];
        mem_wdata = word_q;
        active    = (state != CH_IDLE);
        frozen    = (state == CH_FROZEN);
    end
endmodule

// File: rtl/dma_fz_chk.sv
// Port-level properties of the DMA channel, attached by bind below.
// Assumes a synchronous active-low reset.
module dma_fz_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reinit,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          mem_err,
    input logic          active,
    input logic          frozen,
    input logic          port_err,
    input logic          size_err
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err && !reinit) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R2
    AST_ERR_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_err && !reinit) |=> (frozen && port_err)); // R7
    AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> (active && !mem_req)); // R7
    AST_SIZE_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(size_err) |-> (active && !mem_req)); // R6
    AST_FREEZE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !reinit) |=> frozen); // R8
    AST_REINIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (!active && !frozen && !port_err && !size_err && !mem_req)); // R9
endmodule

bind dma_freeze_chan dma_fz_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reinit   (reinit),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .mem_err  (mem_err),
    .active   (active),
    .frozen   (frozen),
    .port_err (port_err),
    .size_err (size_err)
);

// File: tb/dma_freeze_chan_test.sv
module dma_freeze_chan_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, reinit = 1'b0, err_clr = 1'b0;
    logic [AW-1:0] src_addr = '0, dst_addr = '0;
    logic [SW-1:0] byte_cnt = '0;
    logic          src_hold = 1'b0, dst_hold = 1'b0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          mem_ack = 1'b0, mem_err = 1'b0;
    logic          active, frozen, port_err, size_err;
    logic          inj = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit cmp_on = 0;

    logic [31:0] mem [64];
    logic [31:0] exp_mem [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_freeze_chan #(.AW(AW), .DW(DW), .SW(SW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
        .dst_addr(dst_addr), .byte_cnt(byte_cnt), .src_hold(src_hold),
        .dst_hold(dst_hold), .reinit(reinit), .err_clr(err_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .active(active), .frozen(frozen),
        .port_err(port_err), .size_err(size_err)
    );

    assign mem_rdata = mem[mem_addr[7:2]];

    // Memory responder: answers each request one cycle later.
    always @(posedge clk) begin
        if (mem_req && !mem_ack && !mem_err) begin
            mem_ack <= !inj;
            mem_err <= inj;
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end
        if (mem_req && mem_we && mem_ack && !mem_err) mem[mem_addr[7:2]] <= mem_wdata;
    end

    // Behavioural reference model: 0 idle, 1 read, 2 write, 3 stuck, 4 frozen.
    int          m_st = 0;
    logic [31:0] m_src, m_dst, m_data;
    int          m_left;
    bit          m_sh, m_dh, m_perr, m_serr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_perr = 0; m_serr = 0; m_data = 0;
        end else if (reinit) begin
            m_st = 0; m_perr = 0; m_serr = 0;
        end else begin
            if (err_clr) begin m_perr = 0; m_serr = 0; end
            case (m_st)
                0: if (start) begin
                    if (byte_cnt == 0 || byte_cnt % 4 != 0) begin
                        m_serr = 1; m_st = 3;
                    end else begin
                        m_src = src_addr; m_dst = dst_addr; m_left = byte_cnt / 4;
                        m_sh = src_hold; m_dh = dst_hold; m_st = 1;
                    end
                end
                1: if (mem_err) begin m_perr = 1; m_st = 4; end
                   else if (mem_ack) begin m_data = mem_rdata; m_st = 2; end
                2: if (mem_err) begin m_perr = 1; m_st = 4; end
                   else if (mem_ack) begin
                       if (!m_sh) m_src = m_src + 4;
                       if (!m_dh) m_dst = m_dst + 4;
                       m_left = m_left - 1;
                       m_st = (m_left == 0) ? 0 : 1;
                   end
                default: ;
            endcase
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare design against the model away from the clock edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R5 active", {31'd0, active}, {31'd0, m_st != 0});
            chk("R7 frozen", {31'd0, frozen}, {31'd0, m_st == 4});
            chk("R7 port_err", {31'd0, port_err}, {31'd0, m_perr});
            chk("R6 size_err", {31'd0, size_err}, {31'd0, m_serr});
            chk("R2 mem_req", {31'd0, mem_req}, {31'd0, m_st == 1 || m_st == 2});
            if (m_st == 1 || m_st == 2) begin
                chk("R2 mem_we", {31'd0, mem_we}, {31'd0, m_st == 2});
                chk("R3 mem_addr", mem_addr, (m_st == 2) ? m_dst : m_src);
            end
            if (m_st == 2) chk("R2 mem_wdata", mem_wdata, m_data);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic go(input logic [31:0] s, input logic [31:0] d, input int n, input bit sh, input bit dh);
        @(negedge clk);
        src_addr = s; dst_addr = d; byte_cnt = SW'(n); src_hold = sh; dst_hold = dh; start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && active; i++) @(negedge clk);
    endtask

    task automatic pulse_reinit();
        @(negedge clk); reinit = 1;
        @(negedge clk); reinit = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
    endtask

    task automatic inject(input bit want_we);
        for (int i = 0; i < 100; i++) begin
            if (mem_req && mem_we == want_we && !mem_ack) break;
            @(negedge clk);
        end
        inj = 1;
        @(negedge clk);
        inj = 0;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i] = 32'h1000_0000 + i * 32'h0001_0003;
            exp_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        cmp_on = 1;
        chk("R1 active", {31'd0, active}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
        rst_n = 1;
        @(negedge clk);

        // R2/R3: plain four-word copy
        go(32'h00, 32'h80, 16, 0, 0);
        wait_idle();
        for (int k = 0; k < 4; k++) begin
            exp_mem[32 + k] = exp_mem[k];
            chk("R3 copy", mem[32 + k], exp_mem[32 + k]);
        end

        // R4: fill from one held source word
        go(32'h10, 32'hC0, 12, 1, 0);
        wait_idle();
        for (int k = 0; k < 3; k++) begin
            exp_mem[48 + k] = exp_mem[4];
            chk("R4 fill", mem[48 + k], exp_mem[48 + k]);
        end

        // R4: held destination keeps the last word only
        go(32'h20, 32'hF0, 12, 0, 1);
        wait_idle();
        exp_mem[60] = exp_mem[10];
        chk("R4 held dst", mem[60], exp_mem[60]);
        chk("R4 next word untouched", mem[61], exp_mem[61]);

        // R5: start during a transfer is ignored
        go(32'h40, 32'hA0, 8, 0, 0);
        @(negedge clk);
        go(32'h00, 32'hE0, 4, 0, 0);
        wait_idle();
        exp_mem[40] = exp_mem[16];
        exp_mem[41] = exp_mem[17];
        chk("R5 first copy", mem[40], exp_mem[40]);
        chk("R5 second copy", mem[41], exp_mem[41]);
        chk("R5 ignored start", mem[56], exp_mem[56]);
        chk("R5 active cleared", {31'd0, active}, 32'd0);

        // R6/R8: zero size sticks; err_clr does not release
        go(32'h00, 32'h80, 0, 0, 0);
        chk("R6 size_err", {31'd0, size_err}, 32'd1);
        repeat (4) @(negedge clk);
        chk("R6 still active", {31'd0, active}, 32'd1);
        chk("R6 no request", {31'd0, mem_req}, 32'd0);
        pulse_clr();
        chk("R8 size_err cleared", {31'd0, size_err}, 32'd0);
        chk("R8 still active", {31'd0, active}, 32'd1);
        pulse_reinit();
        chk("R9 idle after size error", {31'd0, active}, 32'd0);

        // R6: size not a whole number of words
        go(32'h00, 32'h80, 6, 0, 0);
        chk("R6 odd size", {31'd0, size_err}, 32'd1);
        pulse_reinit();

        // R7/R8: read error freezes the channel
        go(32'h00, 32'hB0, 16, 0, 0);
        inject(1'b0);
        chk("R7 frozen on read", {31'd0, frozen}, 32'd1);
        chk("R7 port_err", {31'd0, port_err}, 32'd1);
        pulse_clr();
        chk("R8 port_err cleared", {31'd0, port_err}, 32'd0);
        chk("R8 still frozen", {31'd0, frozen}, 32'd1);
        go(32'h00, 32'hB0, 8, 0, 0);
        repeat (4) @(negedge clk);
        chk("R8 start ignored", {31'd0, mem_req}, 32'd0);
        chk("R8 active held", {31'd0, active}, 32'd1);
        pulse_reinit();
        chk("R9 frozen cleared", {31'd0, frozen}, 32'd0);
        chk("R9 active cleared", {31'd0, active}, 32'd0);

        // R9: channel usable after reinit
        go(32'h30, 32'hB0, 8, 0, 0);
        wait_idle();
        exp_mem[44] = exp_mem[12];
        exp_mem[45] = exp_mem[13];
        chk("R9 copy after reinit", mem[44], exp_mem[44]);
        chk("R9 copy after reinit", mem[45], exp_mem[45]);

        // R7: write error freezes before the word lands
        go(32'h00, 32'hD0, 8, 0, 0);
        inject(1'b1);
        chk("R7 frozen on write", {31'd0, frozen}, 32'd1);
        chk("R7 write blocked", mem[52], exp_mem[52]);
        pulse_reinit();

        // R9: reinit beats start in the same cycle
        @(negedge clk);
        src_addr = 32'h00; dst_addr = 32'h80; byte_cnt = 16; start = 1; reinit = 1;
        @(negedge clk);
        start = 0; reinit = 0;
        chk("R9 reinit wins", {31'd0, active}, 32'd0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule